// File: doc/BRIEF.md
# Condition Register Compare-Update Unit

This block keeps a 32-bit condition register built from eight 4-bit fields. Each field holds four flags. From the most significant bit down they are less-than, greater-than, equal and summary-overflow. Field 0 is the top nibble and field 7 is the bottom nibble.

Four kinds of write can reach the register in the same clock cycle:
- a signed result, compared against zero and written to a chosen field;
- an unsigned compare of two 64-bit operands, written to a chosen field;
- a write of one bit, chosen by its absolute bit number;
- a write of the whole 32-bit register.

Both compare updates copy the live summary-overflow flag into the field they write. That flag is taken from bit 31 of the fixed-point exception word supplied at the input.

When several writes aim at the same field, the winner is chosen separately for each field. Writes aimed at different fields all take effect together. A combinational port returns any single bit chosen by its absolute number. The full register value is always visible at the output.

Top module: `cr_update_unit`

## Requirements
- R1: After reset the whole register reads 0x0000_0000.
- R2: Field f occupies register bits 31-4f down to 28-4f. Within a field, bit 3 is less-than, bit 2 is greater-than, bit 1 is equal and bit 0 is summary-overflow.
- R3: A signed update writes less-than when the value is negative, greater-than when it is positive and equal when it is zero.
- R4: An unsigned update of a and b sets exactly one of less-than (a<b), greater-than (a>b) or equal (a==b). The operands are treated as unsigned.
- R5: Every compare update copies bit 31 of the exception word, as seen in the update cycle, into the field's summary-overflow bit.
- R6: A single-bit write with absolute number n (0 to 31) changes only register bit 31-n. Field n/4 holds that bit, and n%4 selects less-than, greater-than, equal or summary-overflow in that order.
- R7: A full write replaces all 32 bits. The register output always shows the whole value.
- R8: For each field, a compare update beats a single-bit write, and a single-bit write beats the full write. A field that loses to the single-bit write keeps its other three bits. Fields that are not contended take their own writes.
- R9: When the signed and unsigned updates target the same field in one cycle, the signed result is written.
- R10: Updates appear on the rising edge after they are presented. With no write enabled, the register holds its value.
- R11: The bit-read port returns register bit 31-n for absolute bit number n, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| exc_word | input | 32 | Fixed-point exception word; bit 31 is summary overflow |
| sgn_en | input | 1 | Signed compare update enable |
| sgn_fld | input | 3 | Target field of the signed update |
| sgn_val | input | 64 | Signed value compared against zero |
| uns_en | input | 1 | Unsigned compare update enable |
| uns_fld | input | 3 | Target field of the unsigned update |
| uns_a | input | 64 | Unsigned operand a |
| uns_b | input | 64 | Unsigned operand b |
| bit_en | input | 1 | Single-bit write enable |
| bit_idx | input | 5 | Absolute bit number to write |
| bit_val | input | 1 | Value for the single-bit write |
| full_en | input | 1 | Full-register write enable |
| full_data | input | 32 | Full-register write data |
| rd_idx | input | 5 | Absolute bit number to read |
| rd_bit | output | 1 | Register bit selected by rd_idx |
| cr_value | output | 32 | Current register contents |

## Verification
The register is visible at its output every cycle. A wrong flag encoding, field position, priority decision or lost hold therefore shows up one edge after the update that caused it. Random mixes of all four writes, with their target fields squeezed so that they collide often, are compared each cycle against a bench model. Directed cases cover zero and extreme operands, summary-overflow toggling, and every pairing of the priority rules.

// File: rtl/cr_pkg.sv
package cr_pkg;
   localparam int FLD_W = 4;

   // Flag positions inside one field
   localparam int POS_LT = 3;
   localparam int POS_GT = 2;
   localparam int POS_EQ = 1;
   localparam int POS_SO = 0;

   typedef struct packed {
      logic lt;
      logic gt;
      logic eq;
      logic so;
   } cr_flags_t;

   function automatic logic [FLD_W-1:0] pack_flags(input cr_flags_t f);
      return {f.lt, f.gt, f.eq, f.so};
   endfunction
endpackage

// File: rtl/cr_cmp_encode.sv
module cr_cmp_encode #(
   parameter int OPND_W      = 64,
   parameter bit SIGNED_MODE = 1'b1
) (
   input  logic [OPND_W-1:0]        opnd_a,
   input  logic [OPND_W-1:0]        opnd_b,
   input  logic                     so_in,
   output logic [cr_pkg::FLD_W-1:0] nib
);
   cr_pkg::cr_flags_t flags;

   generate
      if (SIGNED_MODE) begin : g_signed
         // compare against zero; opnd_b is unused in this variant
         logic unused_b;
         assign unused_b = ^opnd_b;
         always_comb begin
            flags.lt = opnd_a[OPND_W-1];
            flags.eq = (opnd_a == '0);
            flags.gt = !opnd_a[OPND_W-1] && (opnd_a != '0);
            flags.so = so_in;
         end
      end else begin : g_unsigned
         always_comb begin
            flags.lt = (opnd_a < opnd_b);
            flags.gt = (opnd_a > opnd_b);
            flags.eq = (opnd_a == opnd_b);
            flags.so = so_in;
         end
      end
   endgenerate

   assign nib = cr_pkg::pack_flags(flags);
endmodule

// File: rtl/cr_field_slot.sv
module cr_field_slot (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cmp_we,
   input  logic [cr_pkg::FLD_W-1:0] cmp_nib,
   input  logic                     bit_we,
   input  logic [1:0]               bit_sub,
   input  logic                     bit_val,
   input  logic                     full_we,
   input  logic [cr_pkg::FLD_W-1:0] full_nib,
   output logic [cr_pkg::FLD_W-1:0] q
);
   logic [cr_pkg::FLD_W-1:0] bit_merged;

   // sub-index 0 selects the top bit of the field
   always_comb begin
      bit_merged = q;
      bit_merged[2'd3 - bit_sub] = bit_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= '0;
      else if (cmp_we)  q <= cmp_nib;
      else if (bit_we)  q <= bit_merged;
      else if (full_we) q <= full_nib;
   end
endmodule

// File: rtl/cr_update_unit.sv
module cr_update_unit #(
   parameter int NUM_FIELDS = 8,
   parameter int OPND_W     = 64,
   parameter int XER_W      = 32,
   parameter int SO_BIT     = 31,
   localparam int CR_W      = NUM_FIELDS * cr_pkg::FLD_W,
   localparam int FIDX_W    = $clog2(NUM_FIELDS),
   localparam int BIDX_W    = $clog2(CR_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [XER_W-1:0]  exc_word,
   input  logic              sgn_en,
   input  logic [FIDX_W-1:0] sgn_fld,
   input  logic [OPND_W-1:0] sgn_val,
   input  logic              uns_en,
   input  logic [FIDX_W-1:0] uns_fld,
   input  logic [OPND_W-1:0] uns_a,
   input  logic [OPND_W-1:0] uns_b,
   input  logic              bit_en,
   input  logic [BIDX_W-1:0] bit_idx,
   input  logic              bit_val,
   input  logic              full_en,
   input  logic [CR_W-1:0]   full_data,
   input  logic [BIDX_W-1:0] rd_idx,
   output logic              rd_bit,
   output logic [CR_W-1:0]   cr_value
);
   localparam int FW = cr_pkg::FLD_W;

   // elaboration-time parameter checks
   if (NUM_FIELDS < 2 || (1 << FIDX_W) != NUM_FIELDS) begin : g_bad_fields
      $error("NUM_FIELDS must be a power of two, at least 2");
   end
   if (SO_BIT >= XER_W) begin : g_bad_so
      $error("SO_BIT lies outside the exception word");
   end
   if (OPND_W < 2) begin : g_bad_opnd
      $error("OPND_W too small");
   end

   logic [FW-1:0] sgn_nib, uns_nib;
   logic          so_now;

   assign so_now = exc_word[SO_BIT];

   cr_cmp_encode #(.OPND_W(OPND_W), .SIGNED_MODE(1'b1)) u_sgn_enc (
      .opnd_a (sgn_val),
      .opnd_b ('0),
      .so_in  (so_now),
      .nib    (sgn_nib)
   );

   cr_cmp_encode #(.OPND_W(OPND_W), .SIGNED_MODE(1'b0)) u_uns_enc (
      .opnd_a (uns_a),
      .opnd_b (uns_b),
      .so_in  (so_now),
      .nib    (uns_nib)
   );

   logic [FIDX_W-1:0] bit_fld;
   logic [1:0]        bit_sub;
   assign bit_fld = bit_idx[BIDX_W-1:2];
   assign bit_sub = bit_idx[1:0];

   for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
      logic          sgn_hit, uns_hit, bit_hit;
      logic [FW-1:0] cmp_nib, q;

      assign sgn_hit = sgn_en && (sgn_fld == FIDX_W'(f));
      assign uns_hit = uns_en && (uns_fld == FIDX_W'(f));
      assign bit_hit = bit_en && (bit_fld == FIDX_W'(f));
      // signed result wins a same-field clash with the unsigned one
      assign cmp_nib = sgn_hit ? sgn_nib : uns_nib;

      cr_field_slot u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .cmp_we   (sgn_hit | uns_hit),
         .cmp_nib  (cmp_nib),
         .bit_we   (bit_hit),
         .bit_sub  (bit_sub),
         .bit_val  (bit_val),
         .full_we  (full_en),
         .full_nib (full_data[CR_W-1-FW*f -: FW]),
         .q        (q)
      );

      // field 0 lives in the most significant nibble
      assign cr_value[CR_W-1-FW*f -: FW] = q;
   end

   assign rd_bit = cr_value[BIDX_W'(CR_W-1) - rd_idx];
endmodule

// File: rtl/cr_update_chk.sv
module cr_update_chk #(
   parameter int NUM_FIELDS = 8,
   parameter int OPND_W     = 64,
   parameter int XER_W      = 32,
   parameter int SO_BIT     = 31,
   localparam int CR_W      = NUM_FIELDS * 4,
   localparam int FIDX_W    = $clog2(NUM_FIELDS),
   localparam int BIDX_W    = $clog2(CR_W)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [XER_W-1:0]  exc_word,
   input logic              sgn_en,
   input logic [FIDX_W-1:0] sgn_fld,
   input logic [OPND_W-1:0] sgn_val,
   input logic              uns_en,
   input logic [FIDX_W-1:0] uns_fld,
   input logic              bit_en,
   input logic [BIDX_W-1:0] bit_idx,
   input logic              bit_val,
   input logic              full_en,
   input logic [CR_W-1:0]   full_data,
   input logic [CR_W-1:0]   cr_value
);
   function automatic logic [2:0] flags_of(input logic [CR_W-1:0] v, input logic [FIDX_W-1:0] f);
      logic [3:0] n;
      n = v[CR_W-1-4*int'(f) -: 4];
      return n[3:1];
   endfunction

   function automatic logic so_of(input logic [CR_W-1:0] v, input logic [FIDX_W-1:0] f);
      logic [3:0] n;
      n = v[CR_W-1-4*int'(f) -: 4];
      return n[0];
   endfunction

   // R10: no write enabled means the register holds
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(sgn_en || uns_en || bit_en || full_en) |=> $stable(cr_value));

   // R4: unsigned update leaves exactly one ordering flag set
   p_uns_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      uns_en |=> $onehot(flags_of(cr_value, $past(uns_fld))));

   // R5: summary overflow copied into the written field
   p_so_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sgn_en |=> so_of(cr_value, $past(sgn_fld)) == $past(exc_word[SO_BIT]));

   // R3 and R9: signed result lands in its field whatever else targets it
   p_sgn_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sgn_en |=> flags_of(cr_value, $past(sgn_fld)) ==
                 {$past($signed(sgn_val) < 0), $past($signed(sgn_val) > 0), $past(sgn_val == '0)});

   // R7: lone full write replaces every bit
   p_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (full_en && !sgn_en && !uns_en && !bit_en) |=> cr_value == $past(full_data));

   // R6 and R8: single-bit write wins over the full write
   p_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && !sgn_en && !uns_en) |=>
         cr_value[BIDX_W'(CR_W-1) - $past(bit_idx)] == $past(bit_val));
endmodule

bind cr_update_unit cr_update_chk #(
   .NUM_FIELDS (NUM_FIELDS),
   .OPND_W     (OPND_W),
   .XER_W      (XER_W),
   .SO_BIT     (SO_BIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .exc_word  (exc_word),
   .sgn_en    (sgn_en),
   .sgn_fld   (sgn_fld),
   .sgn_val   (sgn_val),
   .uns_en    (uns_en),
   .uns_fld   (uns_fld),
   .bit_en    (bit_en),
   .bit_idx   (bit_idx),
   .bit_val   (bit_val),
   .full_en   (full_en),
   .full_data (full_data),
   .cr_value  (cr_value)
);

// File: tb/tb_cr_update_unit.sv
module tb_cr_update_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] exc_word = '0;
   logic        sgn_en = 1'b0;
   logic [2:0]  sgn_fld = '0;
   logic [63:0] sgn_val = '0;
   logic        uns_en = 1'b0;
   logic [2:0]  uns_fld = '0;
   logic [63:0] uns_a = '0;
   logic [63:0] uns_b = '0;
   logic        bit_en = 1'b0;
   logic [4:0]  bit_idx = '0;
   logic        bit_val = 1'b0;
   logic        full_en = 1'b0;
   logic [31:0] full_data = '0;
   logic [4:0]  rd_idx = '0;
   logic        rd_bit;
   logic [31:0] cr_value;

   int    n_checks = 0;
   int    n_errors = 0;
   bit    done = 1'b0;
   logic [31:0] model = '0;

   always #10ns clk = ~clk;

   cr_update_unit dut (
      .clk(clk), .rst_n(rst_n), .exc_word(exc_word),
      .sgn_en(sgn_en), .sgn_fld(sgn_fld), .sgn_val(sgn_val),
      .uns_en(uns_en), .uns_fld(uns_fld), .uns_a(uns_a), .uns_b(uns_b),
      .bit_en(bit_en), .bit_idx(bit_idx), .bit_val(bit_val),
      .full_en(full_en), .full_data(full_data),
      .rd_idx(rd_idx), .rd_bit(rd_bit), .cr_value(cr_value)
   );

   function automatic logic [31:0] put_nib(input logic [31:0] v, input int f, input logic [3:0] n);
      logic [31:0] r;
      r = v;
      r[31-4*f -: 4] = n;
      return r;
   endfunction

   // next register value from the requirements R3..R9
   function automatic logic [31:0] next_cr(input logic [31:0] cur);
      logic [31:0] r;
      logic        so;
      logic [3:0]  sn, un;
      r  = cur;
      so = exc_word[31];
      sn = {$signed(sgn_val) < 0, $signed(sgn_val) > 0, sgn_val == 64'd0, so};
      un = {uns_a < uns_b, uns_a > uns_b, uns_a == uns_b, so};
      for (int f = 0; f < 8; f++) begin
         bit cmp_hit, bhit;
         cmp_hit = (sgn_en && sgn_fld == 3'(f)) || (uns_en && uns_fld == 3'(f));
         bhit    = bit_en && bit_idx[4:2] == 3'(f);
         if (cmp_hit) begin
            if (sgn_en && sgn_fld == 3'(f)) r = put_nib(r, f, sn);
            else                            r = put_nib(r, f, un);
         end else if (bhit) begin
            r[31 - bit_idx] = bit_val;
         end else if (full_en) begin
            r = put_nib(r, f, full_data[31-4*f -: 4]);
         end
      end
      return r;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle();
      sgn_en = 0; uns_en = 0; bit_en = 0; full_en = 0;
   endtask

   // apply the inputs currently driven, clock once, compare with model
   task automatic step(input string tag);
      model = next_cr(model);
      @(posedge clk);
      @(negedge clk);
      check(tag, cr_value, model);
      idle();
   endtask

   initial begin
      #(20ns * 200000);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_c0de));
      repeat (3) @(negedge clk);
      check("R1 reset value", cr_value, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R7 / R2: full write, then bit reads by absolute number
      full_en = 1; full_data = 32'h8421_0F00;
      step("R7 full write");
      check("R7 literal", cr_value, 32'h8421_0F00);
      rd_idx = 5'd0;  #1ns check("R11 R2 bit0 is field0 LT", 32'(rd_bit), 32'd1);
      rd_idx = 5'd5;  #1ns check("R11 R2 bit5 is field1 GT", 32'(rd_bit), 32'd1);
      rd_idx = 5'd31; #1ns check("R11 R2 bit31 is field7 SO", 32'(rd_bit), 32'd0);

      // R3: negative, zero, positive signed values
      sgn_en = 1; sgn_fld = 3'd2; sgn_val = -64'sd5; exc_word = 32'h0;
      step("R3 negative");
      check("R3 field2 literal", 32'(cr_value[23:20]), 32'h8);
      sgn_en = 1; sgn_fld = 3'd5; sgn_val = 64'd0; exc_word = 32'h8000_0000;
      step("R3 R5 zero with SO");
      check("R5 field5 literal", 32'(cr_value[11:8]), 32'h3);
      sgn_en = 1; sgn_fld = 3'd7; sgn_val = 64'h7FFF_FFFF_FFFF_FFFF; exc_word = 32'h7FFF_FFFF;
      step("R3 R5 max positive, SO clear");
      check("R3 field7 literal", 32'(cr_value[3:0]), 32'h4);

      // R4: unsigned semantics with top bit set
      uns_en = 1; uns_fld = 3'd0; uns_a = 64'd1; uns_b = 64'hFFFF_FFFF_FFFF_FFFF;
      step("R4 unsigned less");
      check("R4 field0 literal", 32'(cr_value[31:28]), 32'h8);
      uns_en = 1; uns_fld = 3'd1; uns_a = 64'h8000_0000_0000_0000; uns_b = 64'h8000_0000_0000_0000;
      step("R4 unsigned equal");

      // R6: single-bit write, bit 30 is field7 EQ
      bit_en = 1; bit_idx = 5'd30; bit_val = 1;
      step("R6 bit30");
      check("R6 bit30 literal", 32'(cr_value[1]), 32'd1);

      // R10: hold
      exc_word = 32'hFFFF_FFFF;
      step("R10 hold");

      // R8: compare over bit over full on field 3; other fields from full
      sgn_en = 1; sgn_fld = 3'd3; sgn_val = 64'd0; exc_word = 32'h0;
      bit_en = 1; bit_idx = 5'd13; bit_val = 1;
      full_en = 1; full_data = 32'hAAAA_AAAA;
      step("R8 compare beats bit and full");
      check("R8 field3 literal", 32'(cr_value[19:16]), 32'h2);
      check("R8 field0 from full", 32'(cr_value[31:28]), 32'hA);
      bit_en = 1; bit_idx = 5'd4; bit_val = 0; full_en = 1; full_data = 32'h0;
      step("R8 bit beats full, field keeps other bits");
      check("R8 field1 literal", 32'(cr_value[27:24]), 32'h2);

      // R9: signed beats unsigned on the same field
      sgn_en = 1; sgn_fld = 3'd6; sgn_val = -64'sd1;
      uns_en = 1; uns_fld = 3'd6; uns_a = 64'd9; uns_b = 64'd1;
      step("R9 signed wins");
      check("R9 field6 literal", 32'(cr_value[7:4]), 32'h8);

      // random mixes with frequent collisions
      for (int i = 0; i < 3000; i++) begin
         sgn_en  = ($urandom % 3) == 0;
         uns_en  = ($urandom % 3) == 0;
         bit_en  = ($urandom % 3) == 0;
         full_en = ($urandom % 4) == 0;
         sgn_fld = 3'($urandom % 3);
         uns_fld = 3'($urandom % 3);
         bit_idx = 5'($urandom % 12);
         if (($urandom % 2) == 0) begin
            sgn_fld = 3'($urandom); uns_fld = 3'($urandom); bit_idx = 5'($urandom);
         end
         bit_val   = 1'($urandom);
         full_data = $urandom;
         exc_word  = $urandom;
         case ($urandom % 4)
            0: sgn_val = 64'd0;
            1: sgn_val = {$urandom, $urandom};
            2: sgn_val = 64'($signed(32'($urandom % 5) - 32'sd2));
            default: sgn_val = {1'b1, 63'd0};
         endcase
         uns_a = {$urandom, $urandom};
         uns_b = (($urandom % 3) == 0) ? uns_a : {$urandom, $urandom};
         step("R3 R4 R5 R6 R7 R8 R9 R10 random");
         rd_idx = 5'($urandom);
         #1ns check("R11 random bit read", 32'(rd_bit), 32'(model[31 - rd_idx]));
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule